// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block is a small direct-mapped cache that serves instruction prefetch requests. It sits between a requester and a simple external bus. Each request carries a 32-bit byte address, a supervisor/user bit and a cachable flag. It also carries a flag that permits a burst. The cache holds 16 lines of four 32-bit long words. Each line has one tag and a valid bit for each long word. Every answer is a single 16-bit instruction half-word.

A request is accepted in `ST_IDLE` when `req_valid` is high. The block then moves to `ST_LOOKUP`, where the addressed tag and valid bit are examined.

- **Hit:** the half-word is returned in that cycle and the block goes back to `ST_IDLE`.
- **Miss:** the block moves to `ST_FETCH`. It drives `bus_req` with the long-word address and waits for `bus_ack`. The first returned long word is forwarded to the requester.
- **Single-word fill:** after the first word, the block returns to `ST_IDLE`.
- **Burst fill:** after the first word, the block enters `ST_FILL`. It takes the remaining three long words in wrap order and returns to `ST_IDLE` after the last one.

A burst is used only when all of the following hold:
- the request is cachable;
- bursting is permitted;
- the line has no valid long word under a matching tag.

A partly valid line with a matching tag is refilled one long word at a time. A synchronous `inv_all` pulse clears every valid bit.

Top module: `icache_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `bus_req` and `rsp_valid` are 0, and every valid bit is clear, so the first access to any address misses.
- R2: The line is chosen by address bits 7:4. The stored tag is the supervisor bit together with address bits 31:8, and a difference in either one is a miss.
- R3: A hit (tag match and the valid bit of the long word at address bits 3:2 set) raises `rsp_valid` in the cycle after acceptance, with no bus request.
- R4: Address bit 1 equal to 0 returns long-word bits 31:16, and equal to 1 returns bits 15:0.
- R5: On a miss `bus_req` rises with `bus_addr` equal to the request address with bits 1:0 cleared, held stable until the transfer ends. The half-word of the first returned long word is the response.
- R6: A cachable miss with burst permitted, where the tag differs or the line has no valid long word, raises `bus_burst`. It takes four long words in wrap order starting at the requested one, and afterwards all four hit.
- R7: A cachable miss whose tag matches while some other long word of the line is valid uses a single non-burst transfer, even when bursting is permitted.
- R8: Writing a new tag on allocation leaves only the fetched long word valid in that line.
- R9: A non-cachable miss never bursts and changes no tag, valid bit or data.
- R10: The response of a burst miss arrives with the first long word. `req_ready` stays 0 while `bus_req` is high, and each request gets exactly one response pulse.
- R11: A cycle with `inv_all` high clears every valid bit, so previously cached words miss afterwards.
- R12: A cachable miss with bursting not permitted fetches and installs only the requested long word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Clear all valid bits this cycle |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block idle; request accepted when both high |
| req_addr | input | 32 | Byte address of the requested half-word |
| req_super | input | 1 | Supervisor (1) or user (0) access |
| req_cachable | input | 1 | Result may be stored in the cache |
| req_burst_ok | input | 1 | A line burst may be requested on a miss |
| rsp_valid | output | 1 | One-cycle pulse carrying the answer |
| rsp_data | output | 16 | Returned instruction half-word |
| bus_req | output | 1 | External transfer in progress |
| bus_burst | output | 1 | Transfer is a four-beat line burst |
| bus_addr | output | 32 | Long-word address of the first beat |
| bus_ack | input | 1 | A long word is on `bus_rdata` this cycle |
| bus_rdata | input | 32 | Returned long word |

## Verification
The bench builds the block with its default parameters: 16 lines of four long words and a 32-bit address. Its reference model assumes exactly this geometry. Random addresses draw from two tag values per line, and a quarter of them set the supervisor bit. This makes tag conflicts, partly valid lines and bursts starting at each of the four long words frequent. The external memory's contents change between requests, so stale, misplaced or missing array writes show up as wrong half-words on later hits.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int LWORD_W = 32;
    localparam int HALF_W  = LWORD_W / 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FETCH,
        ST_FILL
    } ic_state_e;
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store #(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter int TAG_W = 25,
    localparam int IDX_W = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [WORDS-1:0]  rd_vld,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [WSEL_W-1:0] set_word
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [WORDS-1:0] vld_q [LINES];
    logic [WORDS-1:0] set_mask;
    logic             any_vld;

    assign set_mask = WORDS'(1) << set_word;
    assign rd_tag   = tag_q[rd_idx];
    assign rd_vld   = vld_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                tag_q[l] <= '0;
                vld_q[l] <= '0;
            end
        end else begin
            for (int l = 0; l < LINES; l++) begin
                if (inv_all) begin
                    vld_q[l] <= '0;
                end else if (alloc_en && alloc_idx == IDX_W'(l)) begin
                    tag_q[l] <= alloc_tag;
                    vld_q[l] <= (set_en && set_idx == IDX_W'(l)) ? set_mask : '0;
                end else if (set_en && set_idx == IDX_W'(l)) begin
                    vld_q[l] <= vld_q[l] | set_mask;
                end
            end
        end
    end

    always_comb begin
        any_vld = 1'b0;
        for (int l = 0; l < LINES; l++) any_vld = any_vld | (|vld_q[l]);
    end

    logic [IDX_W-1:0] chk_idx_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_idx_q <= '0;
        else        chk_idx_q <= alloc_idx;
    end

    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !any_vld); // R11
    AST_ALLOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en && !inv_all |=> $countones(vld_q[chk_idx_q]) <= 1); // R8
endmodule

// File: rtl/ic_data_store.sv
module ic_data_store #(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx][wr_word] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx][rd_word];
endmodule

// File: rtl/ic_miss_fsm.sv
module ic_miss_fsm
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES = 16,
    parameter int WORDS = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int IDX_LO = 2 + WSEL_W,
    localparam int TAG_LO = IDX_LO + IDX_W,
    localparam int TAG_W = ADDR_W - TAG_LO + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_super,
    input  logic               req_cachable,
    input  logic               req_burst_ok,
    output logic               rsp_valid,
    output logic [HALF_W-1:0]  rsp_data,
    output logic               bus_req,
    output logic               bus_burst,
    output logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_ack,
    input  logic [LWORD_W-1:0] bus_rdata,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [WSEL_W-1:0]  lk_word,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [WORDS-1:0]   lk_vld,
    input  logic [LWORD_W-1:0] lk_data,
    output logic               alloc_en,
    output logic [TAG_W-1:0]   alloc_tag,
    output logic               set_en,
    output logic [WSEL_W-1:0]  fill_word,
    output logic               wr_en
);
    ic_state_e         state_q, state_d;
    logic [ADDR_W-1:0] rq_addr_q;
    logic              rq_super_q, rq_cach_q, rq_bok_q;
    logic [WSEL_W-1:0] beat_q;
    logic              do_burst_q, do_alloc_q;
    logic              tag_match, line_partial, lk_hit;

    function automatic logic [HALF_W-1:0] pick_half(input logic [LWORD_W-1:0] w, input logic sel);
        return sel ? w[HALF_W-1:0] : w[LWORD_W-1:HALF_W];
    endfunction

    assign lk_idx       = rq_addr_q[IDX_LO +: IDX_W];
    assign lk_word      = rq_addr_q[2 +: WSEL_W];
    assign alloc_tag    = {rq_super_q, rq_addr_q[ADDR_W-1:TAG_LO]};
    assign tag_match    = (lk_tag == alloc_tag);
    assign line_partial = tag_match && (|lk_vld);
    assign lk_hit       = tag_match && lk_vld[lk_word];
    assign fill_word    = lk_word + beat_q;
    assign bus_addr     = {rq_addr_q[ADDR_W-1:2], 2'b00};

    // State and datapath register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rq_addr_q  <= '0;
            rq_super_q <= 1'b0;
            rq_cach_q  <= 1'b0;
            rq_bok_q   <= 1'b0;
            beat_q     <= '0;
            do_burst_q <= 1'b0;
            do_alloc_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                rq_addr_q  <= req_addr;
                rq_super_q <= req_super;
                rq_cach_q  <= req_cachable;
                rq_bok_q   <= req_burst_ok;
                beat_q     <= '0;
            end
            if (state_q == ST_LOOKUP) begin
                do_burst_q <= rq_cach_q && rq_bok_q && !line_partial;
                do_alloc_q <= rq_cach_q && !line_partial;
            end
            if ((state_q == ST_FETCH || state_q == ST_FILL) && bus_ack) begin
                beat_q <= beat_q + WSEL_W'(1);
            end
        end
    end

    // Output and next-state process
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        bus_req   = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        alloc_en  = 1'b0;
        set_en    = 1'b0;
        wr_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (lk_hit) begin
                    rsp_valid = 1'b1;
                    rsp_data  = pick_half(lk_data, rq_addr_q[1]);
                    state_d   = ST_IDLE;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    rsp_valid = 1'b1;
                    rsp_data  = pick_half(bus_rdata, rq_addr_q[1]);
                    wr_en     = rq_cach_q;
                    set_en    = rq_cach_q;
                    alloc_en  = do_alloc_q;
                    state_d   = do_burst_q ? ST_FILL : ST_IDLE;
                end
            end
            ST_FILL: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    wr_en  = 1'b1;
                    set_en = 1'b1;
                    if (beat_q == WSEL_W'(WORDS - 1)) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign bus_burst = bus_req && do_burst_q;

    AST_BUS_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && $past(bus_req) |-> $stable(bus_addr)); // R5
    AST_UNCACH_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !rq_cach_q |-> !bus_burst); // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready); // R10
    AST_ONE_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_NOBURST_NO_OK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !rq_bok_q |-> !bus_burst); // R12
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES = 16,
    parameter int WORDS = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int TAG_W = ADDR_W - (2 + WSEL_W + IDX_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_all,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_super,
    input  logic               req_cachable,
    input  logic               req_burst_ok,
    output logic               rsp_valid,
    output logic [HALF_W-1:0]  rsp_data,
    output logic               bus_req,
    output logic               bus_burst,
    output logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_ack,
    input  logic [LWORD_W-1:0] bus_rdata
);
    logic [IDX_W-1:0]   lk_idx;
    logic [WSEL_W-1:0]  lk_word, fill_word;
    logic [TAG_W-1:0]   lk_tag, alloc_tag;
    logic [WORDS-1:0]   lk_vld;
    logic [LWORD_W-1:0] lk_data;
    logic               alloc_en, set_en, wr_en;

    ic_miss_fsm #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_super(req_super), .req_cachable(req_cachable), .req_burst_ok(req_burst_ok),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_burst(bus_burst), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .lk_idx(lk_idx), .lk_word(lk_word), .lk_tag(lk_tag), .lk_vld(lk_vld),
        .lk_data(lk_data), .alloc_en(alloc_en), .alloc_tag(alloc_tag),
        .set_en(set_en), .fill_word(fill_word), .wr_en(wr_en)
    );

    ic_tag_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_vld(lk_vld),
        .alloc_en(alloc_en), .alloc_idx(lk_idx), .alloc_tag(alloc_tag),
        .set_en(set_en), .set_idx(lk_idx), .set_word(fill_word)
    );

    ic_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(LWORD_W)) u_data (
        .clk(clk), .wr_en(wr_en), .wr_idx(lk_idx), .wr_word(fill_word),
        .wr_data(bus_rdata), .rd_idx(lk_idx), .rd_word(lk_word), .rd_data(lk_data)
    );
endmodule

// File: tb/tb_icache_ctrl.sv
`timescale 1ns/1ps
module tb_icache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_all = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_super = 1'b0, req_cachable = 1'b0, req_burst_ok = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        bus_req, bus_burst;
    logic [31:0] bus_addr;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int n_chk = 0, n_err = 0;
    int txn_cnt = 0, beats = 0;
    bit last_burst = 0;
    logic [7:0] gen = 8'd1;

    logic [24:0] m_tag [16];
    logic [3:0]  m_vld [16];
    logic [31:0] m_dat [16][4];

    icache_ctrl dut (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_super(req_super), .req_cachable(req_cachable), .req_burst_ok(req_burst_ok),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_burst(bus_burst), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ {gen, 24'h5A_C3_17};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // External bus model: wrap-order beats starting at the addressed long word
    initial begin
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (bus_req) begin
                logic [31:0] a;
                int n, lat;
                txn_cnt++;
                last_burst = bus_burst;
                a = bus_addr;
                n = bus_burst ? 4 : 1;
                beats = 0;
                lat = 1 + int'($urandom % 3);
                repeat (lat) @(negedge clk);
                for (int i = 0; i < n; i++) begin
                    logic [1:0] w;
                    w = a[3:2] + 2'(i);
                    bus_rdata = memf({a[31:4], w, 2'b00});
                    bus_ack = 1'b1;
                    beats++;
                    @(negedge clk);
                end
                bus_ack = 1'b0;
            end
        end
    end

    task automatic do_req(input logic [31:0] a, input logic sup, input logic cach,
                          input logic bok, input string lbl);
        logic [3:0]  idx;
        logic [1:0]  w;
        logic [24:0] t;
        logic [31:0] exp_word;
        logic [15:0] exp_half, got;
        bit hit, partial, exp_burst, seen;
        int t0, d, b_at;
        bit burst_at;
        idx = a[7:4];
        w = a[3:2];
        t = {sup, a[31:8]};
        hit = (m_tag[idx] == t) && m_vld[idx][w];
        partial = (m_tag[idx] == t) && (|m_vld[idx]);
        exp_burst = !hit && cach && bok && !partial;
        exp_word = hit ? m_dat[idx][w] : memf({a[31:2], 2'b00});
        exp_half = a[1] ? exp_word[15:0] : exp_word[31:16];

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        t0 = txn_cnt;
        req_addr = a; req_super = sup; req_cachable = cach; req_burst_ok = bok;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0; got = '0; b_at = 0; burst_at = 0;
        for (int k = 0; k < 40 && !seen; k++) begin
            #5;
            if (rsp_valid) begin
                seen = 1; got = rsp_data; b_at = beats; burst_at = last_burst;
            end else begin
                @(negedge clk);
            end
        end
        d = txn_cnt - t0;
        chk(seen, lbl, "response seen", 32'(seen), 32'd1);
        chk(got == exp_half, lbl, "half-word", 32'(got), 32'(exp_half));
        chk(d == (hit ? 0 : 1), lbl, "bus transfers (hit=0/miss=1)", 32'(d), hit ? 32'd0 : 32'd1);
        if (!hit && d == 1) begin
            chk(burst_at == exp_burst, lbl, "burst flag", 32'(burst_at), 32'(exp_burst));
            chk(b_at == 1, "R10", "beats before response", 32'(b_at), 32'd1);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);

        if (!hit && cach) begin
            if (!partial) begin
                m_tag[idx] = t;
                m_vld[idx] = '0;
            end
            if (exp_burst) begin
                for (int k = 0; k < 4; k++) m_dat[idx][k] = memf({a[31:4], 2'(k), 2'b00});
                m_vld[idx] = 4'hF;
            end else begin
                m_dat[idx][w] = memf({a[31:2], 2'b00});
                m_vld[idx][w] = 1'b1;
            end
        end
    endtask

    task automatic pulse_inv();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        for (int l = 0; l < 16; l++) m_vld[l] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] A, B, C;
        void'($urandom(32'd20240611));
        for (int l = 0; l < 16; l++) begin
            m_tag[l] = '0; m_vld[l] = '0;
            for (int k = 0; k < 4; k++) m_dat[l][k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
        chk(bus_req == 1'b0, "R1", "bus_req after reset", 32'(bus_req), 32'd0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

        A = 32'h1234_5630;
        do_req(32'h0000_0000, 0, 1, 0, "R1");
        do_req(A, 0, 1, 1, "R6");
        do_req(A + 32'd6, 0, 1, 1, "R4");
        do_req(A + 32'd8, 0, 1, 1, "R3");
        do_req(A + 32'd14, 0, 1, 1, "R6");
        do_req(A + 32'd2, 1, 1, 0, "R2");
        do_req(A + 32'd8, 1, 1, 1, "R7");
        gen = 8'd2;
        B = A ^ 32'h0000_0100;
        do_req(B + 32'd12, 0, 1, 0, "R12");
        do_req(B, 0, 1, 1, "R8");
        C = A ^ 32'h0001_0000;
        do_req(C + 32'd12, 0, 0, 1, "R9");
        do_req(B + 32'd12, 0, 1, 1, "R9");
        do_req(A ^ 32'h0000_0040, 0, 0, 0, "R5");
        pulse_inv();
        do_req(B + 32'd12, 0, 1, 1, "R11");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = {($urandom % 2 == 0) ? 24'hABCDE0 : 24'h13579B, 4'($urandom), 2'($urandom), 1'($urandom), 1'b0};
            if ($urandom % 20 == 0) gen = gen + 8'd1;
            if ($urandom % 40 == 0) pulse_inv();
            do_req(a, ($urandom % 4) == 0, ($urandom % 5) != 0, 1'($urandom), "R6");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule